// File: doc/BRIEF.md
# Floating-Add Reservation Station Bank

This block sits in front of a two-stage pipelined floating-point adder and holds up to three pending operations. Each operation names two operands in two-address form: a source operand and a sink operand, where the sink is also where the result goes. An operand is either present with its value or missing and marked with a nonzero 4-bit producer tag. The bank watches the common data bus (CDB). When a broadcast carries the tag that a missing operand is waiting for, the operand takes the value. Once both operands of a station are present, the station is sent to the adder and becomes free again straight away, without waiting for the result. Results leave the adder through a request/accept handshake toward the CDB.

Each station runs a small state machine with the states SLOT_FREE, SLOT_WAIT and SLOT_READY:
- SLOT_FREE goes to SLOT_WAIT on an allocation with a missing operand.
- SLOT_FREE goes to SLOT_READY on an allocation with both operands present.
- SLOT_WAIT goes to SLOT_READY on the cycle its last missing operand is captured.
- SLOT_READY goes to SLOT_FREE on dispatch.

The adder's occupancy is tracked by a second state machine with the states P_EMPTY, P_FIRST, P_SECOND and P_BOTH:
- P_EMPTY goes to P_FIRST on dispatch.
- P_FIRST goes to P_SECOND, or to P_BOTH if a new dispatch arrives in the same cycle.
- P_SECOND with accept goes to P_EMPTY, or to P_FIRST with a dispatch.
- P_SECOND without accept stays in P_SECOND, or goes to P_BOTH with a dispatch.
- P_BOTH with accept stays in P_BOTH with a dispatch, or goes to P_SECOND without one.
- P_BOTH without accept is a stall and stays in P_BOTH.

Top module: `fadd_rs_bank`

## Requirements
- R1: A synchronous reset frees every station and empties both adder stages. After it, `alloc_full` and `res_req` are low.
- R2: An accepted allocation goes to the lowest-numbered station that is not busy. `alloc_full` is high exactly when all three stations are busy. An allocation made while `alloc_full` is high is ignored and never produces a result.
- R3: An operand allocated with tag 0 is present at once with the supplied data. An operand allocated with a nonzero tag is waiting for that producer.
- R4: On a CDB broadcast, every waiting operand whose tag equals `cdb_tag` takes `cdb_data` at that clock edge. This also applies to an operand being allocated in the same cycle with that tag.
- R5: A station is ready when both its operands are present. At most one station is dispatched per cycle, always the lowest-numbered ready one, and only when the first adder stage can take it. The dispatched station is free in the next cycle.
- R6: `alloc_op` is a 2-bit code. 0 gives sink+source, 1 gives sink−source, 2 gives source−sink and 3 gives source. All results are taken modulo 2^DATA_W.
- R7: With `alloc_short` set, only the low DATA_W/2 bits of the result are kept and the upper half is zero. `res_short` repeats the flag alongside the result.
- R8: A station dispatched in cycle c raises `res_req` after the second rising edge that follows cycle c, provided the second stage is free or leaving at the first of those edges.
- R9: While `res_req` is high and `res_accept` is low, the second stage holds its result unchanged. A full first stage stalls behind it. The result leaves at the edge where both `res_req` and `res_accept` are high.
- R10: While `res_req` is high, `res_tag` equals the parameter RESULT_TAG (nonzero, default 5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alloc_valid | input | 1 | Offer a new operation |
| alloc_op | input | 2 | Operation code |
| alloc_short | input | 1 | Short-precision flag |
| alloc_src_tag | input | TAG_W | Source producer tag, 0 = present |
| alloc_src_data | input | DATA_W | Source value when tag is 0 |
| alloc_snk_tag | input | TAG_W | Sink producer tag, 0 = present |
| alloc_snk_data | input | DATA_W | Sink value when tag is 0 |
| alloc_full | output | 1 | All stations busy |
| cdb_valid | input | 1 | CDB broadcast present |
| cdb_tag | input | TAG_W | Tag of the broadcast |
| cdb_data | input | DATA_W | Value of the broadcast |
| res_req | output | 1 | Adder asks for the CDB |
| res_accept | input | 1 | CDB granted to the adder |
| res_tag | output | TAG_W | Tag of the adder result |
| res_data | output | DATA_W | Adder result |
| res_short | output | 1 | Result was computed in short precision |

## Verification
Operations that are fully present at allocation, with the adder always accepted, exercise the four operation codes and the basic latency. Three operations waiting on one tag, released by a single broadcast while accept is withheld, separate lowest-first dispatch, the stall of both stages and the rejection of a fourth allocation. A broadcast that coincides with an allocation naming its tag checks the same-cycle capture path. Short-precision carries and borrows check the half-width masking. A reset taken with stations busy, followed by a long random mix of allocations, broadcasts and withheld accepts, is compared against a behavioural model on every clock.

// File: rtl/fab_pkg.sv
package fab_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_READY = 2'd2
    } slot_state_e;

    typedef enum logic [1:0] {
        P_EMPTY  = 2'd0,
        P_FIRST  = 2'd1,
        P_SECOND = 2'd2,
        P_BOTH   = 2'd3
    } pipe_state_e;

    // Operation codes: the encoding is visible at the allocation port.
    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_RSUB = 2'd2,
        OP_MOVE = 2'd3
    } add_op_e;
endpackage

// File: rtl/rs_pick.sv
// Lowest-index one-hot grant.
module rs_pick #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    assign gnt = req & (~req + N'(1));
endmodule

// File: rtl/rs_slot.sv
// One reservation station: two tagged operands, op code, precision flag.
module rs_slot
    import fab_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_en,
    input  logic [1:0]        alloc_op,
    input  logic              alloc_short,
    input  logic [TAG_W-1:0]  alloc_src_tag,
    input  logic [DATA_W-1:0] alloc_src_data,
    input  logic [TAG_W-1:0]  alloc_snk_tag,
    input  logic [DATA_W-1:0] alloc_snk_data,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    input  logic              disp_en,
    output logic              busy,
    output logic              ready,
    output logic [1:0]        held_op,
    output logic              held_short,
    output logic [DATA_W-1:0] held_src,
    output logic [DATA_W-1:0] held_snk
);
    localparam int NOPND = 2;   // index 0 = source, 1 = sink

    slot_state_e state_q, state_nx;

    logic [TAG_W-1:0]  new_tag  [NOPND];
    logic [DATA_W-1:0] new_data [NOPND];
    logic [DATA_W-1:0] data_q   [NOPND];
    logic [NOPND-1:0]  full_q;
    logic [NOPND-1:0]  hit;
    logic [NOPND-1:0]  new_full;
    logic              opnd_done;

    assign new_tag[0]  = alloc_src_tag;
    assign new_tag[1]  = alloc_snk_tag;
    assign new_data[0] = alloc_src_data;
    assign new_data[1] = alloc_snk_data;

    for (genvar g = 0; g < NOPND; g++) begin : g_opnd
        logic              new_hit;
        logic              full_r;
        logic [TAG_W-1:0]  tag_r;
        logic [DATA_W-1:0] data_r;

        // operand being allocated meets a broadcast of its own producer
        assign new_hit     = cdb_valid && (new_tag[g] != '0) && (new_tag[g] == cdb_tag);
        assign new_full[g] = (new_tag[g] == '0) || new_hit;
        // operand already held and still waiting
        assign hit[g]      = cdb_valid && busy && !full_r && (tag_r == cdb_tag);

        always_ff @(posedge clk) begin
            if (rst) begin
                full_r <= 1'b0;
                tag_r  <= '0;
                data_r <= '0;
            end else if (alloc_en) begin
                full_r <= new_full[g];
                tag_r  <= new_tag[g];
                data_r <= new_hit ? cdb_data : new_data[g];
            end else if (hit[g]) begin
                full_r <= 1'b1;
                data_r <= cdb_data;
            end
        end

        assign full_q[g] = full_r;
        assign data_q[g] = data_r;
    end

    assign opnd_done = &(full_q | hit);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SLOT_FREE;
        else     state_q <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            SLOT_FREE:  if (alloc_en) state_nx = (&new_full) ? SLOT_READY : SLOT_WAIT;
            SLOT_WAIT:  if (opnd_done) state_nx = SLOT_READY;
            SLOT_READY: if (disp_en) state_nx = SLOT_FREE;
            default:    state_nx = SLOT_FREE;
        endcase
    end

    // outputs
    always_comb begin
        busy  = (state_q != SLOT_FREE);
        ready = (state_q == SLOT_READY);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_op    <= '0;
            held_short <= 1'b0;
        end else if (alloc_en) begin
            held_op    <= alloc_op;
            held_short <= alloc_short;
        end
    end

    assign held_src = data_q[0];
    assign held_snk = data_q[1];
endmodule

// File: rtl/fadd_pipe.sv
// Two-stage adder with CDB request/accept on its second stage.
module fadd_pipe
    import fab_pkg::*;
#(
    parameter int               DATA_W     = 32,
    parameter int               TAG_W      = 4,
    parameter logic [TAG_W-1:0] RESULT_TAG = TAG_W'(5)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        in_op,
    input  logic              in_short,
    input  logic [DATA_W-1:0] in_src,
    input  logic [DATA_W-1:0] in_snk,
    output logic              in_ready,
    output logic              s1_valid,
    output logic              res_req,
    input  logic              res_accept,
    output logic [TAG_W-1:0]  res_tag,
    output logic [DATA_W-1:0] res_data,
    output logic              res_short
);
    localparam int HALF_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] HALF_MASK = {{(DATA_W - HALF_W){1'b0}}, {HALF_W{1'b1}}};

    pipe_state_e state_q, state_nx;

    logic [1:0]        s1_op;
    logic              s1_short;
    logic [DATA_W-1:0] s1_src, s1_snk;
    logic              s2_valid;
    logic              s2_short;
    logic [DATA_W-1:0] s2_data;
    logic              advance;

    function automatic logic [DATA_W-1:0] add_unit(
        input logic [1:0]        op,
        input logic              sh,
        input logic [DATA_W-1:0] a_src,
        input logic [DATA_W-1:0] a_snk
    );
        logic [DATA_W-1:0] r;
        unique case (add_op_e'(op))
            OP_ADD:  r = a_snk + a_src;
            OP_SUB:  r = a_snk - a_src;
            OP_RSUB: r = a_src - a_snk;
            default: r = a_src;
        endcase
        if (sh) r = r & HALF_MASK;
        return r;
    endfunction

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= P_EMPTY;
        else     state_q <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            P_EMPTY:  if (in_valid) state_nx = P_FIRST;
            P_FIRST:  state_nx = in_valid ? P_BOTH : P_SECOND;
            P_SECOND: begin
                if (res_accept) state_nx = in_valid ? P_FIRST : P_EMPTY;
                else            state_nx = in_valid ? P_BOTH  : P_SECOND;
            end
            P_BOTH:   if (res_accept) state_nx = in_valid ? P_BOTH : P_SECOND;
            default:  state_nx = P_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        s1_valid = (state_q == P_FIRST)  || (state_q == P_BOTH);
        s2_valid = (state_q == P_SECOND) || (state_q == P_BOTH);
        in_ready = (state_q != P_BOTH) || res_accept;
        advance  = s1_valid && (!s2_valid || res_accept);
        res_req  = s2_valid;
        res_tag  = s2_valid ? RESULT_TAG : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_op    <= '0;
            s1_short <= 1'b0;
            s1_src   <= '0;
            s1_snk   <= '0;
        end else if (in_valid) begin
            s1_op    <= in_op;
            s1_short <= in_short;
            s1_src   <= in_src;
            s1_snk   <= in_snk;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_data  <= '0;
            s2_short <= 1'b0;
        end else if (advance) begin
            s2_data  <= add_unit(s1_op, s1_short, s1_src, s1_snk);
            s2_short <= s1_short;
        end
    end

    assign res_data  = s2_data;
    assign res_short = s2_short;
endmodule

// File: rtl/fadd_rs_bank.sv
module fadd_rs_bank
    import fab_pkg::*;
#(
    parameter int               NSLOT      = 3,
    parameter int               DATA_W     = 32,
    parameter int               TAG_W      = 4,
    parameter logic [TAG_W-1:0] RESULT_TAG = TAG_W'(5)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic [1:0]        alloc_op,
    input  logic              alloc_short,
    input  logic [TAG_W-1:0]  alloc_src_tag,
    input  logic [DATA_W-1:0] alloc_src_data,
    input  logic [TAG_W-1:0]  alloc_snk_tag,
    input  logic [DATA_W-1:0] alloc_snk_data,
    output logic              alloc_full,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    output logic              res_req,
    input  logic              res_accept,
    output logic [TAG_W-1:0]  res_tag,
    output logic [DATA_W-1:0] res_data,
    output logic              res_short
);
    logic [NSLOT-1:0]  busy_v, ready_v, free_1h, rdy_1h, alloc_grant, disp_grant;
    logic [NSLOT-1:0]  slot_short;
    logic [1:0]        slot_op  [NSLOT];
    logic [DATA_W-1:0] slot_src [NSLOT];
    logic [DATA_W-1:0] slot_snk [NSLOT];
    logic              pipe_take, s1_valid, disp_any;
    logic [1:0]        sel_op;
    logic              sel_short;
    logic [DATA_W-1:0] sel_src, sel_snk;

    assign alloc_full = &busy_v;

    rs_pick #(.N(NSLOT)) u_free_pick (.req(~busy_v), .gnt(free_1h));
    rs_pick #(.N(NSLOT)) u_rdy_pick  (.req(ready_v), .gnt(rdy_1h));

    assign alloc_grant = (alloc_valid && !alloc_full) ? free_1h : '0;
    assign disp_grant  = pipe_take ? rdy_1h : '0;
    assign disp_any    = |disp_grant;

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        rs_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_slot (
            .clk            (clk),
            .rst            (rst),
            .alloc_en       (alloc_grant[i]),
            .alloc_op       (alloc_op),
            .alloc_short    (alloc_short),
            .alloc_src_tag  (alloc_src_tag),
            .alloc_src_data (alloc_src_data),
            .alloc_snk_tag  (alloc_snk_tag),
            .alloc_snk_data (alloc_snk_data),
            .cdb_valid      (cdb_valid),
            .cdb_tag        (cdb_tag),
            .cdb_data       (cdb_data),
            .disp_en        (disp_grant[i]),
            .busy           (busy_v[i]),
            .ready          (ready_v[i]),
            .held_op        (slot_op[i]),
            .held_short     (slot_short[i]),
            .held_src       (slot_src[i]),
            .held_snk       (slot_snk[i])
        );
    end

    // AND-OR select of the dispatched station
    always_comb begin
        sel_op    = '0;
        sel_short = 1'b0;
        sel_src   = '0;
        sel_snk   = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (disp_grant[i]) begin
                sel_op    = sel_op | slot_op[i];
                sel_short = sel_short | slot_short[i];
                sel_src   = sel_src | slot_src[i];
                sel_snk   = sel_snk | slot_snk[i];
            end
        end
    end

    fadd_pipe #(.DATA_W(DATA_W), .TAG_W(TAG_W), .RESULT_TAG(RESULT_TAG)) u_pipe (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (disp_any),
        .in_op      (sel_op),
        .in_short   (sel_short),
        .in_src     (sel_src),
        .in_snk     (sel_snk),
        .in_ready   (pipe_take),
        .s1_valid   (s1_valid),
        .res_req    (res_req),
        .res_accept (res_accept),
        .res_tag    (res_tag),
        .res_data   (res_data),
        .res_short  (res_short)
    );
endmodule

// File: rtl/fadd_rs_chk.sv
module fadd_rs_chk #(
    parameter int NSLOT  = 3,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              alloc_full,
    input logic [NSLOT-1:0]  alloc_grant,
    input logic [NSLOT-1:0]  busy_v,
    input logic [NSLOT-1:0]  ready_v,
    input logic [NSLOT-1:0]  disp_grant,
    input logic              s1_valid,
    input logic              res_req,
    input logic              res_accept,
    input logic [TAG_W-1:0]  res_tag,
    input logic [DATA_W-1:0] res_data,
    input logic              res_short
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!alloc_full && !res_req && busy_v == '0));

    // R2
    full_blocks_alloc_chk: assert property (@(posedge clk) disable iff (rst)
        alloc_full |-> (alloc_grant == '0));

    // R2
    alloc_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (alloc_grant != '0) |=> ((busy_v & $past(alloc_grant)) == $past(alloc_grant)));

    // R5
    one_dispatch_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(disp_grant) && ((disp_grant & ~ready_v) == '0));

    // R5
    dispatch_frees_chk: assert property (@(posedge clk) disable iff (rst)
        (disp_grant != '0) |=> ((busy_v & $past(disp_grant)) == '0));

    // R5
    dispatch_fills_chk: assert property (@(posedge clk) disable iff (rst)
        (disp_grant != '0) |=> s1_valid);

    // R8
    stage_moves_chk: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && (!res_req || res_accept)) |=> res_req);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (res_req && !res_accept) |=>
            (res_req && $stable(res_data) && $stable(res_short) && $stable(res_tag)));
endmodule

bind fadd_rs_bank fadd_rs_chk #(.NSLOT(NSLOT), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .alloc_full  (alloc_full),
    .alloc_grant (alloc_grant),
    .busy_v      (busy_v),
    .ready_v     (ready_v),
    .disp_grant  (disp_grant),
    .s1_valid    (s1_valid),
    .res_req     (res_req),
    .res_accept  (res_accept),
    .res_tag     (res_tag),
    .res_data    (res_data),
    .res_short   (res_short)
);

// File: tb/sim_fadd_rs_bank.sv
`timescale 1ns/1ps
module sim_fadd_rs_bank;
    localparam int DW   = 32;
    localparam int TW   = 4;
    localparam int RTAG = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          alloc_valid = 1'b0;
    logic [1:0]    alloc_op = '0;
    logic          alloc_short = 1'b0;
    logic [TW-1:0] alloc_src_tag = '0;
    logic [DW-1:0] alloc_src_data = '0;
    logic [TW-1:0] alloc_snk_tag = '0;
    logic [DW-1:0] alloc_snk_data = '0;
    logic          alloc_full;
    logic          cdb_valid = 1'b0;
    logic [TW-1:0] cdb_tag = '0;
    logic [DW-1:0] cdb_data = '0;
    logic          res_req;
    logic          res_accept = 1'b0;
    logic [TW-1:0] res_tag;
    logic [DW-1:0] res_data;
    logic          res_short;

    int n_chk = 0;
    int n_err = 0;
    string scen = "R1 reset";

    always #2.5 clk = ~clk;

    fadd_rs_bank #(.NSLOT(3), .DATA_W(DW), .TAG_W(TW), .RESULT_TAG(TW'(RTAG))) u0 (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_op(alloc_op), .alloc_short(alloc_short),
        .alloc_src_tag(alloc_src_tag), .alloc_src_data(alloc_src_data),
        .alloc_snk_tag(alloc_snk_tag), .alloc_snk_data(alloc_snk_data),
        .alloc_full(alloc_full),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .res_req(res_req), .res_accept(res_accept), .res_tag(res_tag),
        .res_data(res_data), .res_short(res_short)
    );

    // ---------------- behavioural reference ----------------
    int          m_busy [3];
    int          m_sf [3], m_kf [3], m_st [3], m_kt [3], m_op [3], m_sh [3];
    logic [31:0] m_sd [3], m_kd [3];
    int          m_p1v = 0, m_p1op = 0, m_p1sh = 0;
    logic [31:0] m_p1s = '0, m_p1k = '0;
    int          m_p2v = 0, m_p2sh = 0;
    logic [31:0] m_p2d = '0;

    function automatic logic [31:0] ref_op(int op, int sh, logic [31:0] s, logic [31:0] k);
        longint r;
        case (op)
            0:       r = longint'(k) + longint'(s);
            1:       r = longint'(k) - longint'(s);
            2:       r = longint'(s) - longint'(k);
            default: r = longint'(s);
        endcase
        r = r & 64'hFFFF_FFFF;
        if (sh != 0) r = r & 64'h0000_FFFF;
        return r[31:0];
    endfunction

    function automatic int model_full();
        return (m_busy[0] != 0 && m_busy[1] != 0 && m_busy[2] != 0) ? 1 : 0;
    endfunction

    task automatic model_tick();
        int acc, adv, take, pick, freei, allf;
        if (rst) begin
            for (int i = 0; i < 3; i++) begin
                m_busy[i] = 0; m_sf[i] = 0; m_kf[i] = 0;
            end
            m_p1v = 0; m_p2v = 0;
            return;
        end
        acc  = (m_p2v != 0 && res_accept) ? 1 : 0;
        adv  = (m_p1v != 0 && (m_p2v == 0 || acc != 0)) ? 1 : 0;
        take = (m_p1v == 0 || adv != 0) ? 1 : 0;
        allf = model_full();
        pick = -1;
        for (int i = 0; i < 3; i++)
            if (pick < 0 && m_busy[i] != 0 && m_sf[i] != 0 && m_kf[i] != 0) pick = i;
        if (take == 0) pick = -1;
        freei = -1;
        if (alloc_valid && allf == 0)
            for (int i = 0; i < 3; i++)
                if (freei < 0 && m_busy[i] == 0) freei = i;
        if (adv != 0) begin
            m_p2v = 1; m_p2sh = m_p1sh; m_p2d = ref_op(m_p1op, m_p1sh, m_p1s, m_p1k);
        end else if (acc != 0) m_p2v = 0;
        if (pick >= 0) begin
            m_p1v = 1; m_p1op = m_op[pick]; m_p1sh = m_sh[pick];
            m_p1s = m_sd[pick]; m_p1k = m_kd[pick];
            m_busy[pick] = 0;
        end else if (adv != 0) m_p1v = 0;
        for (int i = 0; i < 3; i++) begin
            if (m_busy[i] != 0 && cdb_valid) begin
                if (m_sf[i] == 0 && m_st[i] == int'(cdb_tag)) begin m_sf[i] = 1; m_sd[i] = cdb_data; end
                if (m_kf[i] == 0 && m_kt[i] == int'(cdb_tag)) begin m_kf[i] = 1; m_kd[i] = cdb_data; end
            end
        end
        if (freei >= 0) begin
            m_busy[freei] = 1; m_op[freei] = int'(alloc_op); m_sh[freei] = int'(alloc_short);
            m_st[freei] = int'(alloc_src_tag); m_kt[freei] = int'(alloc_snk_tag);
            if (alloc_src_tag == 0) begin m_sf[freei] = 1; m_sd[freei] = alloc_src_data; end
            else if (cdb_valid && cdb_tag == alloc_src_tag) begin m_sf[freei] = 1; m_sd[freei] = cdb_data; end
            else m_sf[freei] = 0;
            if (alloc_snk_tag == 0) begin m_kf[freei] = 1; m_kd[freei] = alloc_snk_data; end
            else if (cdb_valid && cdb_tag == alloc_snk_tag) begin m_kf[freei] = 1; m_kd[freei] = cdb_data; end
            else m_kf[freei] = 0;
        end
    endtask

    // ---------------- checking ----------------
    task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk({scen, " / R2 alloc_full"}, 64'(alloc_full), 64'(model_full()));
        chk({scen, " / R8 res_req"}, 64'(res_req), 64'(m_p2v));
        if (m_p2v != 0) begin
            chk({scen, " / R6 res_data"}, 64'(res_data), 64'(m_p2d));
            chk({scen, " / R7 res_short"}, 64'(res_short), 64'(m_p2sh));
            chk({scen, " / R10 res_tag"}, 64'(res_tag), 64'(RTAG));
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_tick();
        @(negedge clk);
        compare();
        alloc_valid = 1'b0;
        cdb_valid   = 1'b0;
    endtask

    task automatic put(int op, int sh, int st, logic [31:0] sd, int kt, logic [31:0] kd);
        alloc_valid    = 1'b1;
        alloc_op       = 2'(op);
        alloc_short    = sh[0];
        alloc_src_tag  = TW'(st);
        alloc_src_data = sd;
        alloc_snk_tag  = TW'(kt);
        alloc_snk_data = kd;
    endtask

    task automatic bcast(int t, logic [31:0] d);
        cdb_valid = 1'b1;
        cdb_tag   = TW'(t);
        cdb_data  = d;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog R1 act=running exp=finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        rst = 1'b1;
        cyc(); cyc();
        rst = 1'b0;
        chk("R1 alloc_full after reset", 64'(alloc_full), 64'd0);
        chk("R1 res_req after reset", 64'(res_req), 64'd0);

        // R3 / R6: operands present at allocation, every op code, always accepted
        scen = "R3 present operands";
        res_accept = 1'b1;
        put(0, 0, 0, 32'd10, 0, 32'd20);          cyc();
        put(1, 0, 0, 32'd5,  0, 32'd3);           cyc();
        put(2, 0, 0, 32'h100, 0, 32'h30);         cyc();
        put(3, 0, 0, 32'hDEAD_BEEF, 0, 32'h1);    cyc();
        repeat (5) cyc();

        // R2 / R4 / R5 / R9: three waiting stations, fourth rejected, stall
        scen = "R5 lowest-first with R9 hold";
        res_accept = 1'b0;
        put(0, 0, 3, 32'd0, 0, 32'd1000);  cyc();
        put(1, 0, 3, 32'd0, 0, 32'd2000);  cyc();
        put(2, 0, 3, 32'd0, 0, 32'd3000);  cyc();
        chk("R2 full with three waiting", 64'(alloc_full), 64'd1);
        put(0, 0, 0, 32'd7, 0, 32'd7);     cyc();   // ignored
        bcast(3, 32'd100);                 cyc();   // R4 capture
        repeat (6) cyc();
        chk("R9 request held while refused", 64'(res_req), 64'd1);
        res_accept = 1'b1;
        repeat (6) cyc();
        chk("R2 rejected allocation left no result", 64'(res_req), 64'd0);

        // R4: same-cycle capture during allocation
        scen = "R4 same-cycle capture";
        put(1, 0, 7, 32'd0, 6, 32'd0);
        bcast(7, 32'd40);                  cyc();
        bcast(6, 32'd500);                 cyc();
        repeat (5) cyc();

        // R7: short precision carry and borrow
        scen = "R7 short precision";
        put(0, 1, 0, 32'h0000_0001, 0, 32'h0001_FFFF); cyc();
        put(1, 1, 0, 32'h0000_0001, 0, 32'h0000_0000); cyc();
        put(2, 1, 0, 32'h1234_5678, 0, 32'h0000_0001); cyc();
        repeat (5) cyc();

        // R1: reset in mid-run with stations busy
        scen = "R1 reset mid-run";
        res_accept = 1'b0;
        put(0, 0, 2, 32'd0, 0, 32'd1); cyc();
        put(0, 0, 0, 32'd4, 0, 32'd1); cyc();
        put(0, 0, 0, 32'd5, 0, 32'd1); cyc();
        rst = 1'b1; cyc(); rst = 1'b0;
        chk("R1 alloc_full after mid-run reset", 64'(alloc_full), 64'd0);
        chk("R1 res_req after mid-run reset", 64'(res_req), 64'd0);

        // random mix
        scen = "R4 R5 random";
        for (int n = 0; n < 1500; n++) begin
            res_accept = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 1) != 0)
                put(int'($urandom_range(0, 3)), int'($urandom_range(0, 1)),
                    int'($urandom_range(0, 3)), $urandom(),
                    int'($urandom_range(0, 3)), $urandom());
            if ($urandom_range(0, 2) != 0)
                bcast(int'($urandom_range(1, 3)), $urandom());
            cyc();
        end
        // drain
        res_accept = 1'b1;
        for (int n = 0; n < 30; n++) begin
            bcast(1 + (n % 3), 32'(n));
            cyc();
        end
        chk("R2 bank drained", 64'(alloc_full), 64'd0);
        finish_run();
    end
endmodule